// File: doc/BRIEF.md
# Register-Programmed Word Copy Engine

This block moves a run of 32-bit words between host memory and a 4 KiB on-device scratch buffer. Software writes a source address, a destination address and a byte count, then writes a command word. The command word holds a start flag, a direction flag and a flag that requests an interrupt code when the copy ends. The start flag reads back as 1 for as long as the copy runs, so a driver can poll it to see when the copy is done.

Direction 0 means the source is a host address and the destination lies in the buffer window. Direction 1 swaps the two roles. The buffer window starts at device-side address 0x40000 and spans 4096 bytes. Before any data moves, the engine checks that the device-side range fits entirely inside this window; if it does not, the request is dropped. Host addresses are cut to a parameterised width (28 bits by default) and word-aligned. The host side is a request/acknowledge master that carries one word per beat. The buffer side is a single-port RAM interface with one cycle of read latency.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, every register reads 0, the start flag reads 0, `hm_req` and `buf_en` are low and `irq_raise` is 0.
- R2: The register slot is chosen by `reg_addr[7:3]`: 0x80 source, 0x88 destination, 0x90 byte count, 0x98 command. A read returns the whole 64-bit slot combinationally. A write with `reg_wide`=1 at an 8-byte-aligned address replaces all 64 bits. A 32-bit write at the base address replaces bits 31:0, and a 32-bit write at base+4 replaces bits 63:32. Writes with `reg_addr[1:0]`≠0, and wide writes at base+4, are ignored.
- R3: Command bits are: bit 0 starts a copy, bit 1 selects the direction (0: host to buffer, 1: buffer to host), and bit 2 requests the completion code. A command read returns the busy flag in bit 0 and the last accepted bits 2:1.
- R4: The start flag reads 1 from the cycle after an accepted start write until the copy ends. Command writes made while busy are ignored, including their direction and interrupt bits.
- R5: Writes to the source, destination and count registers are ignored while busy.
- R6: The number of words moved is the byte count divided by 4, rounded up. A count of 0 completes without moving any data.
- R7: The device-side address is the destination when the direction is 0 and the source when it is 1. It must satisfy 0x40000 ≤ addr ≤ 0x40FFF. The buffer word index (addr−0x40000)>>2, plus the word count, must not exceed 1024. Otherwise the copy is aborted: nothing is moved, no code is raised, and busy clears two cycles after the start write.
- R8: The host address is the register value masked to `HOST_AW` bits with bits 1:0 cleared. It advances by 4 for each word, and the buffer index advances by 1.
- R9: When bit 2 was set, a copy that ends normally, including a zero-length copy, drives `irq_raise`=0x100 for exactly one cycle. That cycle is the first one in which the start flag reads 0. In every other case `irq_raise` stays 0.
- R10: `hm_req` stays high with stable `hm_we`, `hm_addr` and `hm_wdata` until a cycle with `hm_ack` high. Read data is taken from `hm_rdata` in that cycle.
- R11: Buffer read data on `buf_rdata` is taken in the cycle after the cycle in which `buf_en` is high with `buf_we` low. There is at most one buffer access per cycle, and none while idle.
- R12: Word i of the source range lands at word i of the destination range. No memory word outside the destination range changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 for a 64-bit write, 0 for a 32-bit write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for the slot at `reg_addr` |
| hm_req | output | 1 | Host beat request |
| hm_we | output | 1 | Host beat is a write |
| hm_addr | output | HOST_AW | Host byte address, word aligned |
| hm_wdata | output | 32 | Host write data |
| hm_ack | input | 1 | Host beat accepted |
| hm_rdata | input | 32 | Host read data, valid with `hm_ack` |
| buf_en | output | 1 | Buffer access enable |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | BW | Buffer word index |
| buf_wdata | output | 32 | Buffer write data |
| buf_rdata | input | 32 | Buffer read data, one cycle after the read |
| irq_raise | output | 32 | Completion code, nonzero for one cycle |

## Verification
Register reads settle in the same cycle that the address is applied, so the bench drives `reg_addr` at the falling edge and samples 1 ns later. The start flag is due in the cycle after the write edge, and the bench reads it immediately after every command write. Abort and zero-length requests return to idle one edge later. On a normal copy, the code on `irq_raise` appears in the same cycle that the poll first sees busy clear. The bench therefore counts `irq_raise` at every falling edge and compares the count only after one more idle cycle. Host acknowledges arrive after a random delay and buffer read data is supplied one cycle after `buf_en`. The memory comparison and the beat counts do not depend on exact cycle positions.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_LATCH,
    ST_PUT
  } mv_state_e;

  // Register slots, selected by byte address bits 7:3
  localparam logic [4:0] SLOT_SRC = 5'h10;
  localparam logic [4:0] SLOT_CMD = 5'h13;
  localparam int unsigned N_ADDR_REGS = 3;

  // Merge a 32- or 64-bit write into a 64-bit register
  function automatic logic [63:0] merge_write(input logic [63:0] old_v,
                                              input logic [63:0] wdata,
                                              input logic wide, input logic hi);
    if (wide) return wdata;
    if (hi) return {wdata[31:0], old_v[31:0]};
    return {old_v[63:32], wdata[31:0]};
  endfunction

  // Bytes to whole words, rounded up, safe for the full 64-bit range
  function automatic logic [63:0] word_count(input logic [63:0] bytes);
    return {2'b00, bytes[63:2]} + {63'd0, |bytes[1:0]};
  endfunction

  // Does [addr, addr + 4*words) sit inside the buffer window?
  function automatic logic window_fits(input logic [63:0] addr,
                                       input logic [63:0] words,
                                       input logic [63:0] base,
                                       input logic [63:0] bytes);
    logic [63:0] off;
    if (addr < base) return 1'b0;
    off = addr - base;
    if (off >= bytes) return 1'b0;
    if (words > (bytes >> 2)) return 1'b0;
    return ((off >> 2) + words) <= (bytes >> 2);
  endfunction

  // Host byte address masked to aw bits and word aligned
  function automatic logic [63:0] host_align(input logic [63:0] addr, input int aw);
    logic [63:0] mask;
    mask = (64'd1 << aw) - 64'd1;
    return addr & mask & ~64'd3;
  endfunction

endpackage

// File: rtl/dma_copy_regs.sv
module dma_copy_regs
  import dma_copy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_wide,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  input  logic        busy,
  output logic [63:0] reg_rdata,
  output logic [63:0] src_q,
  output logic [63:0] dst_q,
  output logic [63:0] cnt_q,
  output logic        dir_q,
  output logic        irq_q,
  output logic        launch
);

  logic [63:0] regs_q [N_ADDR_REGS];
  logic [4:0]  slot;
  logic        hi_half;
  logic        wr_ok;
  logic        cmd_wr;

  assign slot    = reg_addr[7:3];
  assign hi_half = reg_addr[2];
  // misaligned and wide-at-upper-half writes never land; nothing lands while busy
  assign wr_ok   = reg_we && (reg_addr[1:0] == 2'b00) && !(reg_wide && hi_half) && !busy;
  assign cmd_wr  = wr_ok && (slot == SLOT_CMD) && !hi_half;
  assign launch  = cmd_wr && reg_wdata[0];

  for (genvar g = 0; g < N_ADDR_REGS; g++) begin : g_addr_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_ok && (slot == SLOT_SRC + 5'(g))) begin
        regs_q[g] <= merge_write(regs_q[g], reg_wdata, reg_wide, hi_half);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (cmd_wr) begin
      dir_q <= reg_wdata[1];
      irq_q <= reg_wdata[2];
    end
  end

  assign src_q = regs_q[0];
  assign dst_q = regs_q[1];
  assign cnt_q = regs_q[2];

  always_comb begin
    reg_rdata = '0;
    if (slot == SLOT_CMD) begin
      reg_rdata = {61'd0, irq_q, dir_q, busy};
    end else if (slot >= SLOT_SRC && slot < SLOT_SRC + 5'(N_ADDR_REGS)) begin
      reg_rdata = regs_q[slot - SLOT_SRC];
    end
  end

endmodule

// File: rtl/dma_copy_mover.sv
module dma_copy_mover
  import dma_copy_pkg::*;
#(
  parameter int          HOST_AW   = 28,
  parameter int          BW        = 10,
  parameter logic [63:0] BUF_BASE  = 64'h40000,
  parameter logic [63:0] BUF_BYTES = 64'd4096,
  parameter logic [31:0] IRQ_CODE  = 32'h100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               dir_q,
  input  logic               irq_q,
  input  logic [63:0]        src_q,
  input  logic [63:0]        dst_q,
  input  logic [63:0]        cnt_q,
  output logic               busy,
  output logic               step,
  output logic               hm_req,
  output logic               hm_we,
  output logic [HOST_AW-1:0] hm_addr,
  output logic [31:0]        hm_wdata,
  input  logic               hm_ack,
  input  logic [31:0]        hm_rdata,
  output logic               buf_en,
  output logic               buf_we,
  output logic [BW-1:0]      buf_addr,
  output logic [31:0]        buf_wdata,
  input  logic [31:0]        buf_rdata,
  output logic [31:0]        irq_raise
);

  mv_state_e          state;
  logic [HOST_AW-1:0] host_ptr;
  logic [BW-1:0]      buf_idx;
  logic [BW:0]        left;
  logic [31:0]        data_q;

  logic [63:0] dev_addr;
  logic [63:0] host_addr;
  logic [63:0] words;
  logic        fits;

  assign dev_addr  = dir_q ? src_q : dst_q;
  assign host_addr = dir_q ? dst_q : src_q;
  assign words     = word_count(cnt_q);
  assign fits      = window_fits(dev_addr, words, BUF_BASE, BUF_BYTES);

  assign busy = (state != ST_IDLE);
  assign step = (state == ST_PUT) && (!dir_q || hm_ack);

  always_comb begin
    hm_req = 1'b0;
    hm_we  = 1'b0;
    buf_en = 1'b0;
    buf_we = 1'b0;
    unique case (state)
      ST_FETCH: begin
        if (!dir_q) hm_req = 1'b1;
        else        buf_en = 1'b1;
      end
      ST_PUT: begin
        if (!dir_q) begin
          buf_en = 1'b1;
          buf_we = 1'b1;
        end else begin
          hm_req = 1'b1;
          hm_we  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign hm_addr   = host_ptr;
  assign hm_wdata  = data_q;
  assign buf_addr  = buf_idx;
  assign buf_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      host_ptr  <= '0;
      buf_idx   <= '0;
      left      <= '0;
      data_q    <= '0;
      irq_raise <= '0;
    end else begin
      irq_raise <= '0;
      unique case (state)
        ST_IDLE: if (launch) state <= ST_CHECK;
        ST_CHECK: begin
          if (!fits) begin
            state <= ST_IDLE;
          end else if (words == 64'd0) begin
            state     <= ST_IDLE;
            irq_raise <= irq_q ? IRQ_CODE : 32'd0;
          end else begin
            host_ptr <= HOST_AW'(host_align(host_addr, HOST_AW));
            buf_idx  <= BW'((dev_addr - BUF_BASE) >> 2);
            left     <= (BW+1)'(words);
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (dir_q) begin
            state <= ST_LATCH;
          end else if (hm_ack) begin
            data_q <= hm_rdata;
            state  <= ST_PUT;
          end
        end
        ST_LATCH: begin
          data_q <= buf_rdata;
          state  <= ST_PUT;
        end
        ST_PUT: begin
          if (step) begin
            left     <= left - 1'b1;
            host_ptr <= host_ptr + HOST_AW'(4);
            buf_idx  <= buf_idx + 1'b1;
            if (left == (BW+1)'(1)) begin
              state     <= ST_IDLE;
              irq_raise <= irq_q ? IRQ_CODE : 32'd0;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int          HOST_AW   = 28,
  parameter logic [63:0] BUF_BASE  = 64'h40000,
  parameter logic [63:0] BUF_BYTES = 64'd4096,
  parameter logic [31:0] IRQ_CODE  = 32'h100,
  localparam int         BW        = $clog2(BUF_BYTES / 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic               reg_wide,
  input  logic [7:0]         reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               hm_req,
  output logic               hm_we,
  output logic [HOST_AW-1:0] hm_addr,
  output logic [31:0]        hm_wdata,
  input  logic               hm_ack,
  input  logic [31:0]        hm_rdata,
  output logic               buf_en,
  output logic               buf_we,
  output logic [BW-1:0]      buf_addr,
  output logic [31:0]        buf_wdata,
  input  logic [31:0]        buf_rdata,
  output logic [31:0]        irq_raise
);

  // named internal events, used by the bound checker
  logic        busy;
  logic        launch;
  logic        step;
  logic [63:0] src_q, dst_q, cnt_q;
  logic        dir_q, irq_q;

  dma_copy_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wide  (reg_wide),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .reg_rdata (reg_rdata),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .dir_q     (dir_q),
    .irq_q     (irq_q),
    .launch    (launch)
  );

  dma_copy_mover #(
    .HOST_AW   (HOST_AW),
    .BW        (BW),
    .BUF_BASE  (BUF_BASE),
    .BUF_BYTES (BUF_BYTES),
    .IRQ_CODE  (IRQ_CODE)
  ) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .dir_q     (dir_q),
    .irq_q     (irq_q),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .busy      (busy),
    .step      (step),
    .hm_req    (hm_req),
    .hm_we     (hm_we),
    .hm_addr   (hm_addr),
    .hm_wdata  (hm_wdata),
    .hm_ack    (hm_ack),
    .hm_rdata  (hm_rdata),
    .buf_en    (buf_en),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .buf_rdata (buf_rdata),
    .irq_raise (irq_raise)
  );

endmodule

// File: rtl/dma_copy_checker.sv
module dma_copy_checker #(
  parameter int          HOST_AW  = 28,
  parameter logic [31:0] IRQ_CODE = 32'h100
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               launch,
  input logic               step,
  input logic               hm_req,
  input logic               hm_we,
  input logic               hm_ack,
  input logic [HOST_AW-1:0] hm_addr,
  input logic [31:0]        hm_wdata,
  input logic               buf_en,
  input logic [63:0]        src_q,
  input logic [63:0]        dst_q,
  input logic [63:0]        cnt_q,
  input logic [31:0]        irq_raise
);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R4

  AST_ADDR_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q))); // R5

  AST_HOST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    hm_req |-> (hm_addr[1:0] == 2'b00)); // R8

  AST_IRQ_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise != 32'd0) |-> ((irq_raise == IRQ_CODE) && !busy)); // R9

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise != 32'd0) |=> (irq_raise == 32'd0)); // R9

  AST_HOST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_req && !hm_ack) |=> (hm_req && $stable(hm_we) && $stable(hm_addr) && $stable(hm_wdata))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!hm_req && !buf_en && !step)); // R11

endmodule

bind dma_copy_engine dma_copy_checker #(
  .HOST_AW  (HOST_AW),
  .IRQ_CODE (IRQ_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .launch    (launch),
  .step      (step),
  .hm_req    (hm_req),
  .hm_we     (hm_we),
  .hm_ack    (hm_ack),
  .hm_addr   (hm_addr),
  .hm_wdata  (hm_wdata),
  .buf_en    (buf_en),
  .src_q     (src_q),
  .dst_q     (dst_q),
  .cnt_q     (cnt_q),
  .irq_raise (irq_raise)
);

// File: tb/sim_dma_copy_engine.sv
module sim_dma_copy_engine;
  localparam int HOST_AW = 28;
  localparam int BW = 10;
  localparam logic [63:0] WIN = 64'h40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_wide = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic hm_req, hm_we, buf_en, buf_we;
  logic [HOST_AW-1:0] hm_addr;
  logic [31:0] hm_wdata, buf_wdata;
  logic hm_ack = 1'b0;
  logic [31:0] hm_rdata = '0, buf_rdata = '0;
  logic [BW-1:0] buf_addr;
  logic [31:0] irq_raise;

  always #10 clk = ~clk;

  dma_copy_engine u0 (.*);

  logic [31:0] hmem [1024];
  logic [31:0] bmem [1024];
  logic [31:0] hexp [1024];
  logic [31:0] bexp [1024];

  int n_chk = 0, n_fail = 0;
  int host_beats = 0, buf_writes = 0, irq_hits = 0;
  logic [31:0] irq_val = '0;
  logic [HOST_AW-1:0] first_haddr = '0;
  bit seen_first = 1'b0;

  // host and buffer models, driven at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      hm_ack = 1'b0;
      if (hm_req && ($urandom_range(0, 2) != 0)) begin
        hm_ack = 1'b1;
        if (!seen_first) begin first_haddr = hm_addr; seen_first = 1'b1; end
        if (hm_we) hmem[hm_addr[11:2]] = hm_wdata;
        else hm_rdata = hmem[hm_addr[11:2]];
        host_beats++;
      end
      if (buf_en) begin
        if (buf_we) begin bmem[buf_addr] = buf_wdata; buf_writes++; end
        else buf_rdata = bmem[buf_addr];
      end
      if (irq_raise != 32'd0) begin irq_hits++; irq_val = irq_raise; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int words_of(input logic [63:0] bytes);
    return int'((bytes + 64'd3) / 64'd4);
  endfunction

  function automatic bit dev_ok(input logic [63:0] a, input int w);
    if (a < WIN || a > WIN + 64'hFFF) return 1'b0;
    return (int'((a - WIN) / 4) + w) <= 1024;
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wide = wide; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic start_xfer(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c,
                            input logic [2:0] cmd);
    logic [63:0] rd;
    reg_write(8'h80, s, 1'b1);
    reg_write(8'h88, d, 1'b1);
    reg_write(8'h90, c, 1'b1);
    host_beats = 0; buf_writes = 0; irq_hits = 0; seen_first = 1'b0;
    reg_write(8'h98, {61'd0, cmd}, 1'b1);
    #1 rd = reg_rdata;
    chk(rd[0] == 1'b1, "R4 start flag after write", rd, 64'd1);
  endtask

  // apply the expected copy to the bench model
  task automatic model_copy(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c,
                            input bit dir, output bit ok, output int w);
    logic [63:0] dev, host;
    w = words_of(c);
    dev  = dir ? s : d;
    host = (dir ? d : s) & 64'h0FFF_FFFC;
    ok = dev_ok(dev, w);
    if (ok) begin
      for (int i = 0; i < w; i++) begin
        if (!dir) bexp[int'((dev - WIN) / 4) + i] = hexp[int'(host / 4) + i];
        else      hexp[int'(host / 4) + i] = bexp[int'((dev - WIN) / 4) + i];
      end
    end
  endtask

  task automatic finish_xfer(input bit ok, input int w, input bit irq_req, input string tag);
    logic [63:0] rd;
    int guard = 0;
    int bad = 0;
    do begin reg_read(8'h98, rd); guard++; end while (rd[0] && guard < 5000);
    chk(rd[0] == 1'b0, {tag, " R4 copy ends"}, rd, 64'd0);
    @(negedge clk); #1;
    chk((ok ? w : 0) == (dir_last ? host_beats : buf_writes), {tag, " R6 R7 words moved"},
        dir_last ? host_beats : buf_writes, ok ? w : 0);
    chk(irq_hits == ((ok && irq_req) ? 1 : 0), {tag, " R9 code count"}, irq_hits, (ok && irq_req) ? 1 : 0);
    if (irq_hits != 0) chk(irq_val == 32'h100, {tag, " R9 code value"}, irq_val, 32'h100);
    for (int i = 0; i < 1024; i++) begin
      if (hmem[i] !== hexp[i] || bmem[i] !== bexp[i]) bad++;
    end
    chk(bad == 0, {tag, " R12 memory contents"}, bad, 0);
  endtask

  bit dir_last = 1'b0;

  task automatic run(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c,
                     input logic [2:0] cmd, input string tag);
    bit ok; int w;
    dir_last = cmd[1];
    model_copy(s, d, c, cmd[1], ok, w);
    start_xfer(s, d, c, cmd);
    finish_xfer(ok, w, cmd[2], tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin
      hmem[i] = $urandom; bmem[i] = $urandom; hexp[i] = hmem[i]; bexp[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(hm_req == 1'b0 && buf_en == 1'b0 && irq_raise == 32'd0, "R1 idle outputs in reset",
        {hm_req, buf_en}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      reg_read(8'(8'h80 + 8 * k), rd);
      chk(rd == 64'd0, "R1 register after reset", rd, 0);
    end

    // R2 register access widths
    reg_write(8'h80, 64'h1122_3344_5566_7788, 1'b1);
    reg_read(8'h80, rd);
    chk(rd == 64'h1122_3344_5566_7788, "R2 wide write", rd, 64'h1122_3344_5566_7788);
    reg_write(8'h88, 64'h0000_0000_AABB_CCDD, 1'b0);
    reg_write(8'h8C, 64'h0000_0000_0102_0304, 1'b0);
    reg_read(8'h88, rd);
    chk(rd == 64'h0102_0304_AABB_CCDD, "R2 split halves", rd, 64'h0102_0304_AABB_CCDD);
    reg_write(8'h8C, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    reg_write(8'h89, 64'h0, 1'b0);
    reg_read(8'h88, rd);
    chk(rd == 64'h0102_0304_AABB_CCDD, "R2 ignored misaligned writes", rd, 64'h0102_0304_AABB_CCDD);
    reg_write(8'h98, 64'h6, 1'b1);
    reg_read(8'h98, rd);
    chk(rd == 64'h6, "R3 command readback", rd, 64'h6);

    // directed corners
    run(64'h100, 64'h40000, 64'd100, 3'b101, "host-to-buf");
    run(64'h40000, 64'h400, 64'd100, 3'b111, "buf-to-host");
    run(64'h200, 64'h40010, 64'd5, 3'b001, "rounding 5 bytes");
    run(64'hF000_0040, 64'h40100, 64'd8, 3'b001, "masked host");
    chk(first_haddr == 28'h40, "R8 host address masked", first_haddr, 28'h40);
    run(64'h300, 64'h40FFC, 64'd8, 3'b101, "past window end");
    run(64'h300, 64'h3FFFC, 64'd4, 3'b101, "below window");
    run(64'h40FFC, 64'h300, 64'd4, 3'b111, "last word");
    run(64'h300, 64'h40020, 64'd0, 3'b101, "zero count");

    // R4 R5 writes while busy are ignored
    dir_last = 1'b0;
    begin
      bit ok; int w;
      model_copy(64'h0, 64'h40000, 64'd256, 1'b0, ok, w);
      start_xfer(64'h0, 64'h40000, 64'd256, 3'b101);
      reg_write(8'h80, 64'h200, 1'b1);
      reg_write(8'h90, 64'd8, 1'b1);
      reg_write(8'h88, 64'h40800, 1'b1);
      reg_write(8'h98, 64'h3, 1'b1);
      finish_xfer(ok, w, 1'b1, "busy writes");
    end
    reg_read(8'h80, rd); chk(rd == 64'h0, "R5 source kept", rd, 0);
    reg_read(8'h90, rd); chk(rd == 64'd256, "R5 count kept", rd, 256);
    reg_read(8'h98, rd); chk(rd == 64'h4, "R4 command kept", rd, 4);

    // constrained random copies
    for (int t = 0; t < 24; t++) begin
      logic [63:0] c, h, dv;
      int w;
      bit dir;
      dir = 1'($urandom_range(0, 1));
      c = 64'($urandom_range(1, 256));
      w = words_of(c);
      h = (64'($urandom_range(0, 15)) << 28) | (64'($urandom_range(0, 900)) << 2);
      dv = WIN + (64'($urandom_range(0, 1024 - w)) << 2);
      if (dir) run(dv, h, c, {1'($urandom_range(0, 1)), 2'b11}, "random");
      else     run(h, dv, c, {1'($urandom_range(0, 1)), 2'b01}, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule